// File: doc/BRIEF.md
# Receive Descriptor Queue Walker

This block hands incoming message segments to receive buffers that software has released to hardware. There are up to 16 independent queues, and each one is a linked list of three-word descriptors held in descriptor memory. Software writes a queue's head descriptor pointer, and the walker then fetches the descriptor at that address. If the descriptor is owned by hardware, the walker gives each accepted segment a destination byte address inside the descriptor's buffer. When a buffer is finished, the walker writes the descriptor back with ownership cleared and reports its address on the completion output. It then follows the next pointer to the following descriptor.

Descriptor layout, as word addresses from the descriptor base:
- Word 0 holds the next-descriptor pointer in bits [15:0]. A value of zero means no successor.
- Word 1 holds the buffer byte address.
- Word 2 holds the ownership flag in bit 31 (1 = hardware owns it), the end-of-queue flag in bit 30, and the buffer length in bytes in bits [12:0]. The length is 256 for a single-segment buffer, or up to 4096 for a multi-segment buffer.

The descriptor memory port has a read latency of one cycle.

Segments arrive on one valid/ready stream. Each segment carries a queue number, a length of 1 to 256 bytes, and a last-of-message flag. While `seg_valid` is high and `seg_ready` is low, the source must hold every segment field stable. A segment is taken only in a cycle where both are high, and `seg_dst` is meaningful only in that cycle. Because the stream is shared, a segment waiting for a queue that cannot accept holds back all traffic behind it.

Descriptor fetches are served one at a time. They rotate among the queues that need a descriptor. A segment offered in an idle cycle is taken in preference to starting a fetch.

Top module: `rxdq_walker`

## Requirements
- R1: While reset is held, `seg_ready`, `cmp_valid` and `mem_req` are 0, and all `starve` bits are 0.
- R2: A head-pointer write to a queue with a nonzero pointer P starts a descriptor fetch. The fetch issues reads at P, P+1 and P+2 in three consecutive cycles.
- R3: A queue whose fetched word 2 has bit 31 = 1 accepts segments. For each accepted segment, `seg_dst` equals the buffer address plus the bytes already placed in that descriptor.
- R4: A descriptor closes when the segment has `seg_last` = 1, or when the bytes placed reach or pass the buffer length. On closing, word 2 is written with bit 31 = 0, bit 30 = end-of-queue, and the length field unchanged.
- R5: Each closed descriptor produces exactly one `cmp_valid` pulse, one cycle long. The pulse carries the queue number and the descriptor address in `cmp_addr`, and it comes in the cycle after the write-back.
- R6: After a completion with a nonzero next pointer, the walker fetches the descriptor at that next pointer. The queue's following segment goes to that descriptor's buffer.
- R7: If a closed descriptor's next pointer is zero, bit 30 is written as 1. After that, segments for that queue are not accepted until the head pointer is written again.
- R8: A fetched descriptor with bit 31 = 0 sets that queue's `starve` bit, and segments for the queue are held. A head-pointer write to the queue clears the bit in the following cycle and fetches again.
- R9: When several queues need a fetch, they are served in rotating order. The search starts at the queue after the last one served.
- R10: A head-pointer write to a queue while that queue's fetch is in flight discards the result of that fetch. The walker then fetches again from the new head.
- R11: A segment for a queue is not accepted in a cycle in which that queue's head pointer is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdp_we | input | 1 | Head-pointer write strobe |
| hdp_qid | input | 4 | Queue number for the head-pointer write |
| hdp_ptr | input | 16 | Head descriptor word address (0 = empty list) |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | Descriptor memory write enable |
| mem_addr | output | 16 | Descriptor memory word address |
| mem_wdata | output | 32 | Descriptor memory write data |
| mem_rdata | input | 32 | Descriptor memory read data, one cycle after the request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be taken this cycle |
| seg_qid | input | 4 | Segment queue number |
| seg_len | input | 9 | Segment length in bytes, 1 to 256 |
| seg_last | input | 1 | Segment ends its message |
| seg_dst | output | 32 | Destination byte address of the accepted segment |
| cmp_valid | output | 1 | Completion pulse |
| cmp_qid | output | 4 | Queue of the completed descriptor |
| cmp_addr | output | 16 | Address of the completed descriptor |
| starve | output | 16 | Per-queue starvation flags |

## Verification
A head-pointer write can land on a queue in the same cycle that a segment for that queue is offered. It can also land in the middle of that queue's descriptor fetch. Both cases are provoked: the write and the segment are driven from the same falling edge, and a second head write is issued one cycle into a fetch. They are judged at the ports. `seg_ready` must be low in the colliding cycle, the read log must show a fresh fetch from the new head, and the next accepted segment must land at offset zero of the new descriptor's buffer.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_RD0,
    EN_RD1,
    EN_RD2,
    EN_RD3,
    EN_WB
  } eng_st_t;

  localparam int OWN_BIT = 31;
  localparam int EOQ_BIT = 30;
endpackage

// File: rtl/rdw_rr_arb.sv
module rdw_rr_arb #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr;
  logic [IW:0]   cand;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int i = 0; i < N; i++) begin
      cand = {1'b0, ptr} + (IW+1)'(i);
      if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
      if (!gnt_any && req[cand[IW-1:0]]) begin
        gnt_any = 1'b1;
        gnt_idx = cand[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (take) ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + IW'(1);
  end

  a_r9_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]);
  a_r9_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !gnt_any);
endmodule

// File: rtl/rdw_qctx.sv
module rdw_qctx #(
  parameter int AW = 16,
  parameter int BW = 32,
  parameter int LW = 13,
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [AW-1:0] arm_ptr_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_next_i,
  input  logic [BW-1:0] ld_buf_i,
  input  logic [LW-1:0] ld_len_i,
  input  logic          starve_i,
  input  logic          done_i,
  input  logic          fill_i,
  input  logic [SW-1:0] fill_len_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] nxt_o,
  output logic [BW-1:0] buf_o,
  output logic [LW-1:0] len_o,
  output logic [LW-1:0] off_o,
  output logic          loaded_o,
  output logic          starve_o,
  output logic          ended_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_o    <= '0;
      nxt_o    <= '0;
      buf_o    <= '0;
      len_o    <= '0;
      off_o    <= '0;
      loaded_o <= 1'b0;
      starve_o <= 1'b0;
      ended_o  <= 1'b1;
    end else if (arm_i) begin
      cur_o    <= arm_ptr_i;
      off_o    <= '0;
      loaded_o <= 1'b0;
      starve_o <= 1'b0;
      ended_o  <= (arm_ptr_i == '0);
    end else if (ld_i) begin
      nxt_o    <= ld_next_i;
      buf_o    <= ld_buf_i;
      len_o    <= ld_len_i;
      off_o    <= '0;
      loaded_o <= 1'b1;
    end else if (starve_i) begin
      starve_o <= 1'b1;
    end else if (done_i) begin
      loaded_o <= 1'b0;
      off_o    <= '0;
      if (nxt_o == '0) ended_o <= 1'b1;
      else cur_o <= nxt_o;
    end else if (fill_i) begin
      off_o <= off_o + LW'(fill_len_i);
    end
  end

  a_r4_fill_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_o |-> ((off_o < len_o) || (off_o == '0)));
  a_r8_starve_not_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    starve_o |-> !loaded_o);
endmodule

// File: rtl/rxdq_walker.sv
module rxdq_walker
  import rdw_pkg::*;
#(
  parameter int NQ = 16,
  parameter int AW = 16,
  parameter int BW = 32,
  parameter int LW = 13,
  parameter int SW = 9,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdp_we,
  input  logic [QW-1:0] hdp_qid,
  input  logic [AW-1:0] hdp_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          seg_valid,
  output logic          seg_ready,
  input  logic [QW-1:0] seg_qid,
  input  logic [SW-1:0] seg_len,
  input  logic          seg_last,
  output logic [BW-1:0] seg_dst,
  output logic          cmp_valid,
  output logic [QW-1:0] cmp_qid,
  output logic [AW-1:0] cmp_addr,
  output logic [NQ-1:0] starve
);
  eng_st_t       st;
  logic [QW-1:0] eng_q;
  logic          stale;
  logic [AW-1:0] eng_base;
  logic [AW-1:0] rd_next;
  logic [BW-1:0] rd_buf;

  logic [AW-1:0] cur_a [NQ];
  logic [AW-1:0] nxt_a [NQ];
  logic [BW-1:0] buf_a [NQ];
  logic [LW-1:0] len_a [NQ];
  logic [LW-1:0] off_a [NQ];
  logic [NQ-1:0] loaded_v, ended_v, need_v;

  logic          acc, close, take, gnt_any, seg_hit, eng_hit;
  logic [QW-1:0] gnt_idx;
  logic [LW:0]   fill_sum;
  logic          unused_rdata;

  assign unused_rdata = ^mem_rdata;
  assign need_v   = ~loaded_v & ~starve & ~ended_v;
  assign seg_hit  = hdp_we && (hdp_qid == seg_qid);
  assign eng_hit  = hdp_we && (hdp_qid == eng_q);
  assign seg_ready = (st == EN_IDLE) && loaded_v[seg_qid] && !seg_hit;
  assign acc      = seg_valid && seg_ready;
  assign fill_sum = {1'b0, off_a[seg_qid]} + (LW+1)'(seg_len);
  assign close    = seg_last || (fill_sum >= {1'b0, len_a[seg_qid]});
  assign seg_dst  = buf_a[seg_qid] + BW'(off_a[seg_qid]);
  assign take     = (st == EN_IDLE) && !acc && gnt_any;

  rdw_rr_arb #(.N(NQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(need_v), .take(take),
    .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic here_rd3;
    assign here_rd3 = (st == EN_RD3) && (eng_q == QW'(q)) && !stale;
    rdw_qctx #(.AW(AW), .BW(BW), .LW(LW), .SW(SW)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .arm_i(hdp_we && (hdp_qid == QW'(q))), .arm_ptr_i(hdp_ptr),
      .ld_i(here_rd3 && mem_rdata[OWN_BIT]),
      .ld_next_i(rd_next), .ld_buf_i(rd_buf), .ld_len_i(mem_rdata[LW-1:0]),
      .starve_i(here_rd3 && !mem_rdata[OWN_BIT]),
      .done_i((st == EN_WB) && (eng_q == QW'(q))),
      .fill_i(acc && !close && (seg_qid == QW'(q))), .fill_len_i(seg_len),
      .cur_o(cur_a[q]), .nxt_o(nxt_a[q]), .buf_o(buf_a[q]), .len_o(len_a[q]),
      .off_o(off_a[q]), .loaded_o(loaded_v[q]), .starve_o(starve[q]),
      .ended_o(ended_v[q])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= EN_IDLE;
      eng_q     <= '0;
      stale     <= 1'b0;
      eng_base  <= '0;
      rd_next   <= '0;
      rd_buf    <= '0;
      cmp_valid <= 1'b0;
      cmp_qid   <= '0;
      cmp_addr  <= '0;
    end else begin
      cmp_valid <= (st == EN_WB);
      cmp_qid   <= eng_q;
      cmp_addr  <= cur_a[eng_q];
      case (st)
        EN_IDLE: begin
          if (acc && close) begin
            st    <= EN_WB;
            eng_q <= seg_qid;
          end else if (take) begin
            st       <= EN_RD0;
            eng_q    <= gnt_idx;
            eng_base <= cur_a[gnt_idx];
            stale    <= hdp_we && (hdp_qid == gnt_idx);
          end
        end
        EN_RD0: begin st <= EN_RD1; stale <= stale || eng_hit; end
        EN_RD1: begin
          st <= EN_RD2; stale <= stale || eng_hit;
          rd_next <= mem_rdata[AW-1:0];
        end
        EN_RD2: begin
          st <= EN_RD3; stale <= stale || eng_hit;
          rd_buf <= mem_rdata[BW-1:0];
        end
        EN_RD3:  st <= EN_IDLE;
        EN_WB:   st <= EN_IDLE;
        default: st <= EN_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = {1'b0, (nxt_a[eng_q] == '0), {(30-LW){1'b0}}, len_a[eng_q]};
    case (st)
      EN_RD0: begin mem_req = 1'b1; mem_addr = eng_base; end
      EN_RD1: begin mem_req = 1'b1; mem_addr = eng_base + AW'(1); end
      EN_RD2: begin mem_req = 1'b1; mem_addr = eng_base + AW'(2); end
      EN_WB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_a[eng_q] + AW'(2); end
      default: ;
    endcase
  end

  a_r5_cmp_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !cmp_valid);
  a_r4_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
  a_r8_starved_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && starve[seg_qid]) |-> !seg_ready);
  a_r2_read_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));
  a_r3_accept_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |-> !mem_req);
endmodule

// File: tb/sim_rxdq_walker.sv
module sim_rxdq_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdp_we = 1'b0;
  logic [3:0]  hdp_qid = '0;
  logic [15:0] hdp_ptr = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [3:0]  seg_qid = '0;
  logic [8:0]  seg_len = '0;
  logic        seg_last = 1'b0;
  logic [31:0] seg_dst;
  logic        cmp_valid;
  logic [3:0]  cmp_qid;
  logic [15:0] cmp_addr;
  logic [15:0] starve;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit wd = 1'b0;

  logic [31:0] mem [64];
  logic        tb_we = 1'b0;
  logic [5:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;
  logic [15:0] rd_addr [64];
  int          rd_cyc [64];
  int          rd_n = 0;
  logic [3:0]  cq_log [16];
  logic [15:0] ca_log [16];
  int          cmp_n = 0;

  always #10 clk = ~clk;

  rxdq_walker u0 (
    .clk(clk), .rst_n(rst_n), .hdp_we(hdp_we), .hdp_qid(hdp_qid), .hdp_ptr(hdp_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_qid(seg_qid), .seg_len(seg_len), .seg_last(seg_last), .seg_dst(seg_dst),
    .cmp_valid(cmp_valid), .cmp_qid(cmp_qid), .cmp_addr(cmp_addr), .starve(starve)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_req && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_req) mem_rdata <= mem[mem_addr[5:0]];
    if (mem_req && !mem_we && rd_n < 64) begin
      rd_addr[rd_n] <= mem_addr;
      rd_cyc[rd_n]  <= cyc;
      rd_n <= rd_n + 1;
    end
    if (cmp_valid && cmp_n < 16) begin
      cq_log[cmp_n] <= cmp_qid;
      ca_log[cmp_n] <= cmp_addr;
      cmp_n <= cmp_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w2(input bit own, input int len);
    return {own, 1'b0, 17'b0, 13'(len)};
  endfunction

  task automatic set_word(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = 6'(a); tb_wd = d;
    @(posedge clk); #1 tb_we = 1'b0;
  endtask

  task automatic set_desc(input int a, input int nxt, input logic [31:0] bufa, input bit own, input int len);
    set_word(a, 32'(nxt));
    set_word(a + 1, bufa);
    set_word(a + 2, w2(own, len));
  endtask

  task automatic arm(input int q, input int ptr);
    @(negedge clk);
    hdp_we = 1'b1; hdp_qid = 4'(q); hdp_ptr = 16'(ptr);
    @(posedge clk); #1 hdp_we = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int q, input int len, input bit last, input int maxw,
                      output bit acc, output logic [31:0] dst);
    acc = 1'b0; dst = '0;
    @(negedge clk);
    seg_valid = 1'b1; seg_qid = 4'(q); seg_len = 9'(len); seg_last = last;
    for (int i = 0; i < maxw; i++) begin
      #1;
      if (seg_ready) begin acc = 1'b1; dst = seg_dst; break; end
      @(negedge clk);
    end
    if (acc) begin @(posedge clk); #1; end
    seg_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    waitc(3);
    chk("R1 seg_ready in reset", 32'(seg_ready), 0);
    chk("R1 cmp_valid in reset", 32'(cmp_valid), 0);
    chk("R1 mem_req in reset", 32'(mem_req), 0);
    chk("R1 starve in reset", 32'(starve), 0);
    rst_n = 1'b1;
    waitc(2);
  endtask

  task automatic t_chain;
    bit a; logic [31:0] d;
    set_desc(8, 16, 32'h1000, 1'b1, 512);
    set_desc(16, 0, 32'h2000, 1'b1, 256);
    arm(3, 8);
    waitc(8);
    chk("R2 first read addr", 32'(rd_addr[0]), 8);
    chk("R2 second read addr", 32'(rd_addr[1]), 9);
    chk("R2 third read addr", 32'(rd_addr[2]), 10);
    chk("R2 reads back to back", 32'(rd_cyc[2] - rd_cyc[0]), 2);
    send(3, 256, 1'b0, 20, a, d);
    chk("R3 first segment accepted", 32'(a), 1);
    chk("R3 first segment dst", d, 32'h1000);
    send(3, 100, 1'b1, 20, a, d);
    chk("R3 second segment dst", d, 32'h1100);
    waitc(4);
    chk("R5 completion count", 32'(cmp_n), 1);
    chk("R5 completion queue", 32'(cq_log[0]), 3);
    chk("R5 completion addr", 32'(ca_log[0]), 8);
    chk("R4 writeback word2 own cleared", mem[10], 32'h0000_0200);
    send(3, 256, 1'b0, 20, a, d);
    chk("R6 next descriptor fetched", 32'(rd_addr[3]), 16);
    chk("R6 segment into next buffer", d, 32'h2000);
    waitc(4);
    chk("R4 length close completion", 32'(cmp_n), 2);
    chk("R4 length close addr", 32'(ca_log[1]), 16);
    chk("R7 eoq written", mem[18], 32'h4000_0100);
    send(3, 16, 1'b1, 15, a, d);
    chk("R7 ended queue holds segment", 32'(a), 0);
  endtask

  task automatic t_starve;
    bit a; logic [31:0] d;
    set_desc(24, 0, 32'h3000, 1'b0, 256);
    arm(5, 24);
    waitc(8);
    chk("R8 starve flag set", 32'(starve[5]), 1);
    send(5, 64, 1'b1, 15, a, d);
    chk("R8 starved queue holds segment", 32'(a), 0);
    set_word(26, w2(1'b1, 256));
    arm(5, 24);
    chk("R8 rearm clears starve", 32'(starve[5]), 0);
    send(5, 64, 1'b1, 30, a, d);
    chk("R8 segment after rearm", d, 32'h3000);
    waitc(4);
    chk("R8 completion queue", 32'(cq_log[2]), 5);
    chk("R8 completion addr", 32'(ca_log[2]), 24);
  endtask

  task automatic t_rr;
    int b;
    set_desc(32, 0, 32'h6000, 1'b0, 256);
    set_desc(40, 0, 32'h7000, 1'b0, 256);
    set_desc(48, 0, 32'h8000, 1'b0, 256);
    b = rd_n;
    arm(6, 32);
    arm(2, 48);
    arm(9, 40);
    waitc(20);
    chk("R9 first fetch q6", 32'(rd_addr[b]), 32);
    chk("R9 rotation serves q9 before q2", 32'(rd_addr[b+3]), 40);
    chk("R9 then q2", 32'(rd_addr[b+6]), 48);
    chk("R9 starve bits", 32'(starve & 16'h0244), 32'h0244);
  endtask

  task automatic t_rearm_race;
    bit a; logic [31:0] d; int b;
    set_desc(56, 0, 32'h4000, 1'b1, 256);
    set_desc(60, 0, 32'h5000, 1'b1, 256);
    b = rd_n;
    arm(7, 56);
    arm(7, 60);
    waitc(12);
    chk("R10 first fetch at old head", 32'(rd_addr[b]), 56);
    chk("R10 refetch at new head", 32'(rd_addr[b+3]), 60);
    send(7, 32, 1'b0, 20, a, d);
    chk("R10 segment into new head buffer", d, 32'h5000);
    @(negedge clk);
    hdp_we = 1'b1; hdp_qid = 4'd7; hdp_ptr = 16'd60;
    seg_valid = 1'b1; seg_qid = 4'd7; seg_len = 9'd32; seg_last = 1'b1;
    #1 chk("R11 segment blocked by head write", 32'(seg_ready), 0);
    @(posedge clk); #1 hdp_we = 1'b0; seg_valid = 1'b0;
    send(7, 32, 1'b1, 20, a, d);
    chk("R11 rearm restarts at offset zero", d, 32'h5000);
    waitc(4);
    chk("R11 completion addr", 32'(ca_log[3]), 60);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    fork
      begin
        t_reset();
        t_chain();
        t_starve();
        t_rr();
        t_rearm_race();
      end
      begin
        repeat (20000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule